// File: doc/BRIEF.md
# Masked-Byte CRC Wake-Pattern Matcher

This block watches a received Ethernet frame that arrives one byte per clock. It holds four independent pattern slots. Each slot owns a 64-bit byte-select mask, made of four 16-bit words, and a 32-bit expected CRC value. While the frame streams in, every slot keeps its own running CRC-32, but only over the frame bytes its mask selects. Bytes are numbered from 1, and the window reaches byte 64.

When the last byte has been taken, each slot compares its complemented CRC with its expected value. Every matching slot raises a wake pulse that lasts one cycle, and a combined flag reports whether any slot matched. A slot whose mask is entirely zero is switched off. The slots are configured through a plain 16-bit write/read register port.

Frame framing works as follows. `rx_sof` is a strobe cycle that carries no data. The bytes that follow are marked by `rx_valid`, and the final byte also carries `rx_eof`.

Top module: `wake_crc_matcher`

## Requirements
- R1: After reset every configuration register reads 0, and no wake output is raised until a frame has ended.
- R2: Register address = slot*8 + k. For k = 0..3 the register is mask word k, where bit b selects frame byte 16k+b+1. k = 4 holds CRC[15:0] and k = 5 holds CRC[31:16]. Offsets k = 6 and 7 read 0 and ignore writes. Writes take effect on the clock edge where `cfg_we` is high, and reads are combinational.
- R3: The slot CRC is the reflected CRC-32 (polynomial 0x04C11DB7). It is preset to all ones, takes each byte least significant bit first, and is complemented before the compare. Nine selected bytes "123456789" give 0xCBF43926.
- R4: A byte whose mask bit is 0 has no effect on the slot's result.
- R5: Frame bytes after byte 64 never enter any slot's CRC.
- R6: An `rx_sof` strobe restarts every slot's CRC and the byte count. The first valid byte after it is byte 1, and a frame that is cut off without `rx_eof` produces no pulse.
- R7: A slot whose four mask words are all zero never signals a match, even when its expected CRC equals the empty-frame CRC (0x00000000).
- R8: `wake_hit[s]` is high for exactly the one cycle after the end-of-frame byte, and only when slot s matches.
- R9: `wake_any` is the OR of the four `wake_hit` bits.
- R10: A frame shorter than the mask window is evaluated using only the selected bytes that actually arrived.
- R11: The slots are independent. In one frame each slot gives its own result from its own mask and expected CRC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_sof | input | 1 | Start-of-frame strobe, no data |
| rx_valid | input | 1 | Frame byte present |
| rx_eof | input | 1 | Marks the last frame byte, together with rx_valid |
| rx_data | input | 8 | Frame byte |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 5 | Register address {slot, k} |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data |
| wake_hit | output | 4 | Per-slot one-cycle match pulse |
| wake_any | output | 1 | OR of wake_hit |

## Verification
The first directed frame contains the nine-byte check string inside a longer frame. It separates a correct reflected CRC with final inversion from any other bit order or preset, and it separates a matching slot from a neighbour whose expected value is off by one bit. A sparse alternating mask is used with bytes flipped outside the selection and then inside it, which shows that masked-out bytes are truly ignored. A 100-byte frame with a change after byte 64 exercises the window limit. A 10-byte frame checked against a 32-byte mask exercises short-frame evaluation. An all-zero mask paired with an expected value of zero tells a disabled slot apart from an enabled empty one. A frame that is cut off by a fresh start strobe shows that the CRC restarts.

// File: rtl/wcm_pkg.sv
package wcm_pkg;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [31:0] CRC_PRESET    = 32'hFFFFFFFF;

  // one byte step of the reflected CRC-32, lsb of the byte first
  function automatic logic [31:0] crc32_step(input logic [31:0] c_in, input logic [7:0] d);
    logic [31:0] c;
    c = c_in;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ d[i]) c = (c >> 1) ^ CRC_POLY_REFL;
      else             c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/wcm_cfg_regs.sv
module wcm_cfg_regs #(
  parameter int SLOTS = 4,
  parameter int WORDS = 4,
  parameter int DW    = 16,
  parameter int AW    = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [AW-1:0]             addr,
  input  logic [DW-1:0]             wdata,
  output logic [DW-1:0]             rdata,
  output logic [SLOTS*WORDS*DW-1:0] mask_flat,
  output logic [SLOTS*2*DW-1:0]     crc_flat
);
  localparam int SB = AW - 3;

  logic [DW-1:0] mask_q [SLOTS][WORDS];
  logic [DW-1:0] clo_q  [SLOTS];
  logic [DW-1:0] chi_q  [SLOTS];

  logic [SB-1:0] a_slot;
  logic [2:0]    a_reg;
  assign a_slot = addr[AW-1:3];
  assign a_reg  = addr[2:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SLOTS; s++) begin
        clo_q[s] <= '0;
        chi_q[s] <= '0;
        for (int w = 0; w < WORDS; w++) mask_q[s][w] <= '0;
      end
    end else if (we) begin
      for (int s = 0; s < SLOTS; s++) begin
        if (a_slot == SB'(s)) begin
          for (int w = 0; w < WORDS; w++)
            if (a_reg == 3'(w)) mask_q[s][w] <= wdata;
          if (a_reg == 3'd4) clo_q[s] <= wdata;
          if (a_reg == 3'd5) chi_q[s] <= wdata;
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int s = 0; s < SLOTS; s++) begin
      if (a_slot == SB'(s)) begin
        for (int w = 0; w < WORDS; w++)
          if (a_reg == 3'(w)) rdata = mask_q[s][w];
        if (a_reg == 3'd4) rdata = clo_q[s];
        if (a_reg == 3'd5) rdata = chi_q[s];
      end
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_flat
    for (genvar w = 0; w < WORDS; w++) begin : g_word
      assign mask_flat[(s*WORDS+w)*DW +: DW] = mask_q[s][w];
    end
    assign crc_flat[s*2*DW +: 2*DW] = {chi_q[s], clo_q[s]};
  end

endmodule

// File: rtl/wcm_slot.sv
module wcm_slot #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          byte_en,
  input  logic          byte_sel,
  input  logic [7:0]    byte_in,
  input  logic          done,
  input  logic          slot_en,
  input  logic [CW-1:0] exp_crc,
  output logic          hit
);
  import wcm_pkg::*;

  logic [CW-1:0] crc_q;
  logic [CW-1:0] crc_final;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   crc_q <= CRC_PRESET;
    else if (restart)             crc_q <= CRC_PRESET;
    else if (byte_en && byte_sel) crc_q <= crc32_step(crc_q, byte_in);
  end

  assign crc_final = ~crc_q;
  assign hit       = done && slot_en && (crc_final == exp_crc);

endmodule

// File: rtl/wake_crc_matcher.sv
module wake_crc_matcher #(
  parameter int SLOTS = 4,
  parameter int WORDS = 4,
  parameter int DW    = 16,
  parameter int AW    = $clog2(SLOTS) + 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_sof,
  input  logic             rx_valid,
  input  logic             rx_eof,
  input  logic [7:0]       rx_data,
  input  logic             cfg_we,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [DW-1:0]    cfg_wdata,
  output logic [DW-1:0]    cfg_rdata,
  output logic [SLOTS-1:0] wake_hit,
  output logic             wake_any
);
  localparam int WIN = WORDS * DW;
  localparam int SW  = $clog2(WIN);
  localparam int IW  = $clog2(WIN + 1);

  logic [SLOTS*WIN-1:0]  mask_flat;
  logic [SLOTS*2*DW-1:0] crc_flat;
  logic [IW-1:0]         idx_q;
  logic                  frame_done;
  logic                  byte_ok;
  logic                  in_win;
  logic [SLOTS-1:0]      slot_en;
  logic [SLOTS-1:0]      slot_sel;

  wcm_cfg_regs #(.SLOTS(SLOTS), .WORDS(WORDS), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .mask_flat(mask_flat), .crc_flat(crc_flat)
  );

  assign byte_ok = rx_valid && !rx_sof;
  assign in_win  = idx_q < IW'(WIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q      <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= byte_ok && rx_eof;
      if (rx_sof)                idx_q <= '0;
      else if (byte_ok && in_win) idx_q <= idx_q + 1'b1;
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [WIN-1:0] smask;
    assign smask       = mask_flat[s*WIN +: WIN];
    assign slot_en[s]  = |smask;
    assign slot_sel[s] = in_win && smask[idx_q[SW-1:0]];

    wcm_slot #(.CW(2*DW)) u_slot (
      .clk(clk), .rst_n(rst_n), .restart(rx_sof), .byte_en(byte_ok),
      .byte_sel(slot_sel[s]), .byte_in(rx_data), .done(frame_done),
      .slot_en(slot_en[s]), .exp_crc(crc_flat[s*2*DW +: 2*DW]), .hit(wake_hit[s])
    );
  end

  assign wake_any = |wake_hit;

endmodule

// File: rtl/wcm_checker.sv
module wcm_checker #(
  parameter int SLOTS = 4,
  parameter int DW    = 16,
  parameter int AW    = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_sof,
  input logic             rx_valid,
  input logic             rx_eof,
  input logic [AW-1:0]    cfg_addr,
  input logic [DW-1:0]    cfg_rdata,
  input logic [SLOTS-1:0] wake_hit,
  input logic             wake_any,
  input logic             frame_done
);
  logic seen_end;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_end <= 1'b0;
    else if (rx_valid && rx_eof && !rx_sof) seen_end <= 1'b1;
  end

  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_end |-> (wake_hit == '0));

  p_hole_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr[2:1] == 2'b11) |-> (cfg_rdata == '0));

  p_sof_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_sof |=> (wake_hit == '0));

  p_done_after_eof_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(rx_valid && rx_eof && !rx_sof));

  p_hit_needs_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_hit != '0) |-> frame_done);

  p_any_is_or_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_any == (wake_hit != '0));

endmodule

bind wake_crc_matcher wcm_checker #(.SLOTS(SLOTS), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_sof(rx_sof), .rx_valid(rx_valid), .rx_eof(rx_eof),
  .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata), .wake_hit(wake_hit),
  .wake_any(wake_any), .frame_done(frame_done)
);

// File: tb/sim_wake_crc_matcher.sv
`timescale 1ns/1ps
module sim_wake_crc_matcher;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_sof = 1'b0, rx_valid = 1'b0, rx_eof = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic [3:0]  wake_hit;
  logic        wake_any;

  int checks = 0, errors = 0;
  logic [7:0]  frm [0:127];
  logic [63:0] bm  [4];
  logic [31:0] ec  [4];
  logic [3:0]  got_hit;
  logic        got_any;
  logic [3:0]  after_hit;

  always #10 clk = ~clk;

  wake_crc_matcher u0 (
    .clk(clk), .rst_n(rst_n), .rx_sof(rx_sof), .rx_valid(rx_valid), .rx_eof(rx_eof),
    .rx_data(rx_data), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .wake_hit(wake_hit), .wake_any(wake_any)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // MSB-first CRC on bit-reversed bytes, reversed back at the end
  function automatic logic [31:0] ref_crc(input int s, input int len);
    logic [31:0] c = 32'hFFFFFFFF;
    logic [31:0] r;
    for (int i = 0; i < len; i++) begin
      if (i < 64 && bm[s][i]) begin
        for (int k = 0; k < 8; k++) begin
          logic fb;
          fb = c[31] ^ frm[i][k];
          c = c << 1;
          if (fb) c = c ^ 32'h04C11DB7;
        end
      end
    end
    c = ~c;
    for (int k = 0; k < 32; k++) r[k] = c[31-k];
    return r;
  endfunction

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic cfg_slot(input int s);
    for (int w = 0; w < 4; w++) wr(5'(s*8 + w), bm[s][16*w +: 16]);
    wr(5'(s*8 + 4), ec[s][15:0]);
    wr(5'(s*8 + 5), ec[s][31:16]);
  endtask

  task automatic cfg_all();
    for (int s = 0; s < 4; s++) cfg_slot(s);
  endtask

  task automatic send_frame(input int len);
    logic early = 1'b0;
    @(negedge clk); rx_sof = 1'b1;
    @(negedge clk); rx_sof = 1'b0;
    for (int i = 0; i < len; i++) begin
      rx_valid = 1'b1; rx_data = frm[i]; rx_eof = (i == len - 1);
      #1 if (wake_any) early = 1'b1;
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_eof = 1'b0;
    #1 got_hit = wake_hit; got_any = wake_any;
    @(negedge clk); #1 after_hit = wake_hit;
    chk(!early, "R8 no pulse before end", 32'(early), 0);
    chk(after_hit == 4'b0, "R8 pulse lasts one cycle", 32'(after_hit), 0);
    chk(got_any == (got_hit != 0), "R9 any is OR", 32'(got_any), 32'(got_hit != 0));
  endtask

  task automatic t_reset();
    logic bad = 1'b0;
    for (int a = 0; a < 32; a++) begin
      @(negedge clk); cfg_addr = 5'(a); #1 if (cfg_rdata != 0) bad = 1'b1;
    end
    chk(!bad, "R1 registers zero after reset", 32'(bad), 0);
    chk(wake_hit == 0 && !wake_any, "R1 outputs quiet after reset", 32'(wake_hit), 0);
  endtask

  task automatic t_regs();
    wr(5'd0, 16'hA5C3); wr(5'd13, 16'h1234); wr(5'd30, 16'hBEEF); wr(5'd29, 16'h0F0F);
    wr(5'd6, 16'hFFFF); wr(5'd15, 16'h7777);
    @(negedge clk); cfg_addr = 5'd0;  #1 chk(cfg_rdata == 16'hA5C3, "R2 mask word readback", 32'(cfg_rdata), 32'hA5C3);
    @(negedge clk); cfg_addr = 5'd13; #1 chk(cfg_rdata == 16'h1234, "R2 crc high readback", 32'(cfg_rdata), 32'h1234);
    @(negedge clk); cfg_addr = 5'd30; #1 chk(cfg_rdata == 16'h0000, "R2 offset 6 reads zero", 32'(cfg_rdata), 0);
    @(negedge clk); cfg_addr = 5'd29; #1 chk(cfg_rdata == 16'h0F0F, "R2 crc high slot3", 32'(cfg_rdata), 32'h0F0F);
    @(negedge clk); cfg_addr = 5'd6;  #1 chk(cfg_rdata == 16'h0000, "R2 write to hole ignored", 32'(cfg_rdata), 0);
    @(negedge clk); cfg_addr = 5'd15; #1 chk(cfg_rdata == 16'h0000, "R2 offset 7 ignored", 32'(cfg_rdata), 0);
    @(negedge clk); cfg_addr = 5'd8;  #1 chk(cfg_rdata == 16'h0000, "R2 other slot untouched", 32'(cfg_rdata), 0);
  endtask

  task automatic t_basic();
    string s9 = "123456789";
    for (int i = 0; i < 20; i++) frm[i] = 8'(8'h40 + i);
    for (int i = 0; i < 9; i++) frm[i] = s9[i];
    bm[0] = 64'h1FF; ec[0] = 32'hCBF43926;
    bm[1] = 64'h1FF; ec[1] = 32'hCBF43927;
    bm[2] = 64'h0;   ec[2] = 32'h0;
    bm[3] = 64'hFFFF_0000_0000_0000; ec[3] = 32'h1;
    cfg_all();
    send_frame(20);
    chk(got_hit == 4'b0001, "R3 R11 check string matches slot0 only", 32'(got_hit), 32'h1);
    chk(got_any, "R9 any raised on match", 32'(got_any), 1);
    // R7: a disabled slot whose expected value equals the empty CRC
    bm[0] = 64'h0; ec[0] = 32'h0;
    cfg_slot(0);
    send_frame(20);
    chk(got_hit == 4'b0000, "R7 zero-mask slot silent", 32'(got_hit), 0);
  endtask

  task automatic t_mask();
    for (int i = 0; i < 64; i++) frm[i] = 8'(i * 37 + 5);
    bm[0] = 64'h0; ec[0] = 0;
    bm[1] = 64'h5555_AAAA_0F0F_3C3C; ec[1] = ref_crc(1, 64);
    bm[2] = 64'hFFFF_FFFF_FFFF_FFFF; ec[2] = ref_crc(2, 64);
    bm[3] = 64'h0; ec[3] = 0;
    cfg_all();
    send_frame(64);
    chk(got_hit == 4'b0110, "R11 two slots match", 32'(got_hit), 32'h6);
    frm[0] = ~frm[0];   // bit 0 of mask1 is 0
    send_frame(64);
    chk(got_hit == 4'b0010, "R4 unselected byte ignored", 32'(got_hit), 32'h2);
    frm[2] = ~frm[2];   // bit 2 of mask1 is 1
    send_frame(64);
    chk(got_hit == 4'b0000, "R4 selected byte changes result", 32'(got_hit), 0);
  endtask

  task automatic t_window();
    for (int i = 0; i < 100; i++) frm[i] = 8'(i ^ 8'h5A);
    bm[0] = 64'hFFFF_0000_0000_0000; ec[0] = ref_crc(0, 100);
    bm[1] = 64'h0; ec[1] = 0; bm[2] = 64'h0; ec[2] = 0;
    bm[3] = 64'h8000_0000_0000_0001; ec[3] = ref_crc(3, 100);
    cfg_all();
    frm[69] = 8'hEE; frm[64] = 8'h11;
    send_frame(100);
    chk(got_hit == 4'b1001, "R5 bytes past 64 excluded", 32'(got_hit), 32'h9);
  endtask

  task automatic t_short();
    for (int i = 0; i < 10; i++) frm[i] = 8'(8'hC0 - i);
    bm[0] = 64'h0000_0000_FFFF_FFFF; ec[0] = ref_crc(0, 10);
    bm[1] = 64'h0; ec[1] = 0; bm[2] = 64'h0; ec[2] = 0;
    bm[3] = 64'h0000_0000_FFFF_FFFF; ec[3] = ref_crc(3, 32) ^ 32'h0000_0100;
    cfg_all();
    send_frame(10);
    chk(got_hit == 4'b0001, "R10 short frame uses received bytes", 32'(got_hit), 32'h1);
  endtask

  task automatic t_restart();
    // cut-off frame: no end strobe, then a fresh frame
    @(negedge clk); rx_sof = 1'b1;
    @(negedge clk); rx_sof = 1'b0;
    for (int i = 0; i < 5; i++) begin
      rx_valid = 1'b1; rx_data = 8'hFF; @(negedge clk);
    end
    rx_valid = 1'b0; #1
    chk(wake_hit == 0, "R6 cut-off frame no pulse", 32'(wake_hit), 0);
    send_frame(10);
    chk(got_hit == 4'b0001, "R6 restart counts from byte 1", 32'(got_hit), 32'h1);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_basic();
    t_mask();
    t_window();
    t_short();
    t_restart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule